// File: doc/BRIEF.md
# Hashed Inverted Page Table Frame Search

This block finds the physical frame that holds a given virtual page of a given process, using an inverted page table. That table keeps exactly one entry per physical frame. Each entry records which process owns the frame and which virtual page is mapped into it. The frame number is never stored. It is simply the position of the entry in the table.

A request brings a process ID, a 19-bit virtual page number and a 13-bit page offset. The block hashes the page number with the process ID to choose a starting slot. It then reads one table entry per cycle, stepping forward one slot at a time and wrapping at the end of the table. It stops when an entry matches or when a fixed number of probes has been spent. The answer is a one-cycle done pulse with a hit flag, the frame index and the physical address. The physical address is the frame index placed above the page offset.

The table sits outside the block behind a synchronous read port with one cycle of latency. Software fills the table; the block only searches it.

Top module: `ipt_frame_search`

## Requirements
- R1: After reset, req_ready is 1, and rsp_done, rsp_hit and tbl_rd_en are all 0.
- R2: In the cycle a request is accepted (req_valid and req_ready both high), tbl_rd_en is 1. In that same cycle, tbl_addr is the start slot: the low FRAME_W bits of the page number XOR the low FRAME_W bits of the process ID, taken modulo the table size 2^FRAME_W.
- R3: After the first read, one read is issued per cycle. The address rises by one each time and wraps from 2^FRAME_W-1 to 0.
- R4: Table word layout: the top bit is the valid flag, the next PID_W bits are the owner process ID, and the low VPN_W bits are the virtual page number. An entry matches only if the valid flag is 1 and both the process ID and the full page number are equal. An invalid entry, a different owner, or a page number that differs only in its high bits does not match.
- R5: If the entry read on probe k matches (k = 0 for the start slot), rsp_done pulses k+2 cycles after the accept edge. With it, rsp_hit is 1, rsp_frame is the slot index, and rsp_paddr is {rsp_frame, offset}.
- R6: If none of the first PROBE_LIMIT probes matches, the result is a miss. rsp_done pulses PROBE_LIMIT+1 cycles after the accept edge, with rsp_hit, rsp_frame and rsp_paddr all 0. Exactly PROBE_LIMIT reads are issued.
- R7: A search that hits on probe k issues exactly k+1 table reads. No read is issued after the matching entry is seen.
- R8: req_ready is 0 from the accept edge until the edge that raises rsp_done. Requests offered while req_ready is 0 are ignored and do not change the result.
- R9: rsp_done lasts a single cycle, and rsp_hit is never 1 without rsp_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Search request present |
| req_pid | input | PID_W | Process ID of the request |
| req_vpn | input | VPN_W | Virtual page number |
| req_off | input | OFF_W | Page offset, carried into the physical address |
| req_ready | output | 1 | Block is idle and will accept a request |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_addr | output | FRAME_W | Table slot to read |
| tbl_rd_data | input | PID_W+VPN_W+1 | Entry read from the table, valid one cycle after the strobe |
| rsp_done | output | 1 | One-cycle result strobe |
| rsp_hit | output | 1 | Matching entry found |
| rsp_frame | output | FRAME_W | Frame number, which is the matching slot index |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address {frame, offset} |

## Verification
Several properties are checked on every cycle:
- Consecutive reads inside a search step by one slot and wrap at the end of the table.
- No search spends more than the probe limit on reads.
- The done strobe is a single-cycle pulse and only ends a search that was in flight.
- A miss always carries a zero frame and a zero address.

The bench scenarios are needed for the rest:
- The hash start slot.
- The matching rule against invalid entries, foreign owners and page numbers that differ only in their high bits.
- The exact latency and read count for a hit on the first probe, a hit on the last probe and a miss one slot past the limit.
- Requests being ignored while a search is running.

// File: rtl/ipt_frame_search.sv
module ipt_frame_search #(
  parameter int PID_W       = 8,
  parameter int VPN_W       = 19,
  parameter int OFF_W       = 13,
  parameter int FRAME_W     = 6,
  parameter int PROBE_LIMIT = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [PID_W-1:0]           req_pid,
  input  logic [VPN_W-1:0]           req_vpn,
  input  logic [OFF_W-1:0]           req_off,
  output logic                       req_ready,
  output logic                       tbl_rd_en,
  output logic [FRAME_W-1:0]         tbl_addr,
  input  logic [PID_W+VPN_W:0]       tbl_rd_data,
  output logic                       rsp_done,
  output logic                       rsp_hit,
  output logic [FRAME_W-1:0]         rsp_frame,
  output logic [FRAME_W+OFF_W-1:0]   rsp_paddr
);
  localparam int DEPTH = 1 << FRAME_W;
  localparam int LIMIT = (PROBE_LIMIT > DEPTH) ? DEPTH : ((PROBE_LIMIT < 1) ? 1 : PROBE_LIMIT);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

  logic               busy_q;
  logic [PID_W-1:0]   pid_q;
  logic [VPN_W-1:0]   vpn_q;
  logic [OFF_W-1:0]   off_q;
  logic [FRAME_W-1:0] nxt_q;
  logic [CNT_W-1:0]   issued_q;
  logic               pend_q;
  logic               pend_last_q;
  logic [FRAME_W-1:0] pend_idx_q;

  logic               accept;
  logic               more;
  logic               match;
  logic               give_up;
  logic [FRAME_W-1:0] start_slot;

  wire               ent_valid = tbl_rd_data[PID_W+VPN_W];
  wire [PID_W-1:0]   ent_pid   = tbl_rd_data[PID_W+VPN_W-1:VPN_W];
  wire [VPN_W-1:0]   ent_vpn   = tbl_rd_data[VPN_W-1:0];

  assign start_slot = req_vpn[FRAME_W-1:0] ^ FRAME_W'(req_pid);
  assign accept     = req_valid & ~busy_q;
  assign match      = pend_q & ent_valid & (ent_pid == pid_q) & (ent_vpn == vpn_q);
  assign give_up    = pend_q & ~match & pend_last_q;
  assign more       = busy_q & ~match & (issued_q < LIMIT_C);

  assign req_ready  = ~busy_q;
  assign tbl_rd_en  = accept | more;
  assign tbl_addr   = accept ? start_slot : nxt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      pid_q       <= '0;
      vpn_q       <= '0;
      off_q       <= '0;
      nxt_q       <= '0;
      issued_q    <= '0;
      pend_q      <= 1'b0;
      pend_last_q <= 1'b0;
      pend_idx_q  <= '0;
    end else if (accept) begin
      busy_q      <= 1'b1;
      pid_q       <= req_pid;
      vpn_q       <= req_vpn;
      off_q       <= req_off;
      nxt_q       <= start_slot + 1'b1;
      issued_q    <= CNT_W'(1);
      pend_q      <= 1'b1;
      pend_idx_q  <= start_slot;
      pend_last_q <= (LIMIT == 1);
    end else if (busy_q) begin
      if (match || give_up) begin
        busy_q <= 1'b0;
        pend_q <= 1'b0;
      end else if (more) begin
        nxt_q       <= nxt_q + 1'b1;
        issued_q    <= issued_q + 1'b1;
        pend_q      <= 1'b1;
        pend_idx_q  <= nxt_q;
        pend_last_q <= (issued_q + 1'b1 == LIMIT_C);
      end else begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_done  <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_frame <= '0;
      rsp_paddr <= '0;
    end else begin
      rsp_done  <= match | give_up;
      rsp_hit   <= match;
      rsp_frame <= match ? pend_idx_q : '0;
      rsp_paddr <= match ? {pend_idx_q, off_q} : '0;
    end
  end

  logic [CNT_W:0] chk_reads;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         chk_reads <= '0;
    else if (accept)    chk_reads <= (CNT_W+1)'(1);
    else if (tbl_rd_en) chk_reads <= chk_reads + 1'b1;
  end

  // R3
  probe_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd_en && busy_q && $past(tbl_rd_en)) |-> tbl_addr == FRAME_W'($past(tbl_addr) + 1'b1));

  // R6
  read_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_reads <= (CNT_W+1)'(LIMIT));

  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rsp_hit) |-> (rsp_frame == '0 && rsp_paddr == '0));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R9
  hit_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_done);

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(!req_ready));
endmodule

// File: tb/tb_ipt_frame_search.sv
`timescale 1ns/1ps
module tb_ipt_frame_search;
  localparam int PID_W = 8, VPN_W = 19, OFF_W = 13, FRAME_W = 6, LIM = 8;
  localparam int DEPTH = 1 << FRAME_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [PID_W-1:0] req_pid = '0;
  logic [VPN_W-1:0] req_vpn = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic req_ready, tbl_rd_en, rsp_done, rsp_hit;
  logic [FRAME_W-1:0] tbl_addr, rsp_frame;
  logic [PID_W+VPN_W:0] tbl_rd_data = '0;
  logic [FRAME_W+OFF_W-1:0] rsp_paddr;

  logic [PID_W+VPN_W:0] mem [DEPTH];
  int rd_cnt = 0;
  int checks = 0, fails = 0, cyc = 0;

  ipt_frame_search #(.PID_W(PID_W), .VPN_W(VPN_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W),
                     .PROBE_LIMIT(LIM)) dut (.*);

  always #2 clk = ~clk;

  always @(posedge clk) if (tbl_rd_en) begin
    tbl_rd_data <= mem[tbl_addr];
    rd_cnt <= rd_cnt + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FRAME_W-1:0] hsh(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v);
    return v[FRAME_W-1:0] ^ p[FRAME_W-1:0];
  endfunction

  function automatic logic [PID_W+VPN_W:0] ent(input logic vld, input logic [PID_W-1:0] p,
                                               input logic [VPN_W-1:0] v);
    return {vld, p, v};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  endtask

  task automatic run_search(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v,
                            input logic [OFF_W-1:0] o, input bit exp_hit, input int exp_frame,
                            input int exp_lat, input int exp_reads, input string tag);
    int lat, r0;
    @(negedge clk);
    r0 = rd_cnt;
    check({tag, " R2 rd_en at accept"}, tbl_rd_en, 0);
    req_valid = 1; req_pid = p; req_vpn = v; req_off = o;
    #0.5;
    check({tag, " R2 start slot"}, tbl_addr, hsh(p, v));
    check({tag, " R2 read strobe"}, tbl_rd_en, 1);
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!rsp_done && lat < 40) begin @(negedge clk); lat++; end
    check({tag, exp_hit ? " R5 latency" : " R6 latency"}, lat, exp_lat);
    check({tag, exp_hit ? " R5 hit" : " R6 hit"}, rsp_hit, exp_hit);
    check({tag, exp_hit ? " R5 frame" : " R6 frame"}, rsp_frame, exp_frame);
    check({tag, exp_hit ? " R5 paddr" : " R6 paddr"}, rsp_paddr,
          exp_hit ? {exp_frame[FRAME_W-1:0], o} : 0);
    check({tag, exp_hit ? " R7 reads" : " R6 reads"}, rd_cnt - r0, exp_reads);
    @(negedge clk);
    check({tag, " R9 done single cycle"}, rsp_done, 0);
  endtask

  task automatic t_reset();
    check("R1 req_ready", req_ready, 1);
    check("R1 rsp_done", rsp_done, 0);
    check("R1 rsp_hit", rsp_hit, 0);
    check("R1 tbl_rd_en", tbl_rd_en, 0);
  endtask

  task automatic t_direct();
    logic [FRAME_W-1:0] h;
    clear_mem();
    h = hsh(8'h0A, 19'h00123);
    mem[h] = ent(1, 8'h0A, 19'h00123);
    run_search(8'h0A, 19'h00123, 13'h1ABC, 1, h, 2, 1, "direct");
  endtask

  task automatic t_wrap();
    clear_mem();
    mem[62] = ent(1, 8'h01, 19'h00040);
    mem[63] = ent(1, 8'h02, 19'h00041);
    mem[0]  = ent(1, 8'h03, 19'h00042);
    mem[1]  = ent(1, 8'h3E, 19'h00040);
    run_search(8'h3E, 19'h00040, 13'h0005, 1, 1, 5, 4, "wrap R3");
  endtask

  task automatic t_match_rule();
    logic [FRAME_W-1:0] h;
    clear_mem();
    h = hsh(8'h21, 19'h55507);
    mem[h]       = ent(0, 8'h21, 19'h55507);
    mem[h+6'd1]  = ent(1, 8'h61, 19'h55507);
    mem[h+6'd2]  = ent(1, 8'h21, 19'h15507);
    mem[h+6'd3]  = ent(1, 8'h21, 19'h55507);
    run_search(8'h21, 19'h55507, 13'h1FFF, 1, h + 6'd3, 5, 4, "R4 invalid/pid/highvpn");
  endtask

  task automatic t_last_probe();
    logic [FRAME_W-1:0] h;
    clear_mem();
    h = hsh(8'h11, 19'h00007);
    mem[h + 6'd7] = ent(1, 8'h11, 19'h00007);
    run_search(8'h11, 19'h00007, 13'h0100, 1, h + 6'd7, 9, 8, "last probe");
  endtask

  task automatic t_miss();
    logic [FRAME_W-1:0] h;
    clear_mem();
    h = hsh(8'h11, 19'h00007);
    mem[h + 6'd8] = ent(1, 8'h11, 19'h00007);
    run_search(8'h11, 19'h00007, 13'h0100, 0, 0, 9, 8, "miss past limit");
    run_search(8'h33, 19'h7FFFF, 13'h0ABC, 0, 0, 9, 8, "miss empty");
  endtask

  task automatic t_busy();
    logic [FRAME_W-1:0] ha, hb;
    int lat;
    clear_mem();
    ha = hsh(8'h04, 19'h00200);
    hb = hsh(8'h09, 19'h00333);
    mem[ha + 6'd2] = ent(1, 8'h04, 19'h00200);
    mem[hb]        = ent(1, 8'h09, 19'h00333);
    @(negedge clk);
    req_valid = 1; req_pid = 8'h04; req_vpn = 19'h00200; req_off = 13'h0077;
    @(negedge clk);
    check("R8 ready low while busy", req_ready, 0);
    req_pid = 8'h09; req_vpn = 19'h00333; req_off = 13'h0055;
    lat = 1;
    while (!rsp_done && lat < 40) begin @(negedge clk); lat++; end
    req_valid = 0;
    check("R8 latency unaffected", lat, 4);
    check("R8 frame from first request", rsp_frame, ha + 6'd2);
    check("R8 paddr from first request", rsp_paddr, {ha + 6'd2, 13'h0077});
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R8 ignored request not run", rsp_done, 0);
    end
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_wrap();
    t_match_rule();
    t_last_probe();
    t_miss();
    t_busy();
    t_direct();
    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule